// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen asynchronous external lines and turns chosen
transitions on them into latched interrupt requests. Each line is first
brought into the clock domain through two flip-flops, then compared with
its previous synchronized value to find rising and falling transitions.

Software chooses which lines react to rising transitions, which react to
falling ones, and which may reach the outputs, by writing three
configuration registers over a simple write port. A qualifying transition
sets a sticky pending flag for its line. A pending flag stays set until
software writes a 1 to that line's position in the clear register.

The masked pending flags are folded onto seven request outputs. Lines 0 to
4 each own an output. Lines 5 to 9 share one output, and lines 10 to 15
share another.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every configuration register and every pending flag is zero, so `irq_out` is 0.
- R2: When line n's rising enable (bit n of register select 0) is 1, a low-to-high change on `line_in[n]` sets pending flag n.
- R3: When line n's falling enable (bit n of register select 1) is 1, a high-to-low change on `line_in[n]` sets pending flag n.
- R4: With both enables set, either direction of change sets the pending flag.
- R5: A change in a direction whose enable is 0 leaves the pending flag untouched.
- R6: Output bits see pending flag n only while mask bit n (register select 2) is 1. A pending flag stays latched while masked and appears once the mask is set.
- R7: A write to register select 3 clears every pending flag whose `wr_data` bit is 1. Bits written as 0 have no effect.
- R8: If a qualifying change is detected in the same cycle as a clear of the same line, the pending flag ends up set.
- R9: `irq_out[n]` serves line n for n = 0..4. `irq_out[5]` is the OR of lines 5..9 and `irq_out[6]` is the OR of lines 10..15, in each case taken over pending AND mask.
- R10: An input change applied before clock edge k shows on `irq_out` right after edge k+2. A configuration write applied before edge k takes effect right after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 16 | Asynchronous external lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 rising enable, 1 falling enable, 2 mask, 3 pending clear |
| wr_data | input | 16 | Write data, one bit per line |
| irq_out | output | 7 | Folded interrupt requests |

## Verification
A detected transition and a software clear of the same pending flag can fall in the same cycle. The bench provokes this by raising a line and then issuing the clear write so that it lands on the edge where that transition reaches the pending logic, two edges after the line was sampled. It then requires the line's request to remain high. A behavioural model keeps a history of the sampled inputs and recomputes the pending flags every cycle. Its output is compared with `irq_out` on every clock, so any disagreement in when a flag sets or clears is reported.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [LINES-1:0] wr_data,
  output logic [6:0]       irq_out
);
  localparam int DIRECT = 5;
  localparam int GRP_A_HI = 9;

  logic [LINES-1:0] sync1, sync2, last;
  logic [LINES-1:0] rise_en, fall_en, mask, pend;
  logic [LINES-1:0] hit, clr, active;

  assign hit    = (sync2 & ~last & rise_en) | (~sync2 & last & fall_en);
  assign clr    = (wr_en && wr_sel == 2'd3) ? wr_data : '0;
  assign active = pend & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      mask    <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0:    rise_en <= wr_data;
        2'd1:    fall_en <= wr_data;
        2'd2:    mask    <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | hit;
  end

  for (genvar i = 0; i < DIRECT; i++) begin : g_direct
    assign irq_out[i] = active[i];
  end
  assign irq_out[5] = |active[GRP_A_HI:DIRECT];
  assign irq_out[6] = |active[LINES-1:GRP_A_HI+1];

  // R7: a written 1 without a simultaneous hit empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & $past(clr & ~hit)) == '0);

  // R8: a detected hit always leaves its flag set
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (pend & $past(hit)) == $past(hit));

  // R5: a flag can only rise on a line that has some enable
  a_r5_no_enable_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend)) & ~$past(rise_en | fall_en)) == '0);

  // R7: without a clear, a set flag holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> (pend & $past(pend)) == $past(pend));

  // R6: a masked line never drives a request
  a_r6_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> irq_out == '0);
endmodule

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] line_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [6:0]  irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  edge_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  logic [15:0] h0 = '0, h1 = '0, h2 = '0;
  logic [15:0] m_rise = '0, m_fall = '0, m_mask = '0, m_pend = '0;

  function automatic logic [6:0] fold(input logic [15:0] a);
    logic [6:0] r;
    for (int i = 0; i < 5; i++) r[i] = a[i];
    r[5] = |a[9:5];
    r[6] = |a[15:10];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 = '0; h1 = '0; h2 = '0;
      m_rise = '0; m_fall = '0; m_mask = '0; m_pend = '0;
    end else begin
      logic [15:0] ev, cl;
      ev = (h1 & ~h2 & m_rise) | (~h1 & h2 & m_fall);
      cl = (wr_en && wr_sel == 2'd3) ? wr_data : '0;
      m_pend = (m_pend & ~cl) | ev;
      if (wr_en) begin
        if (wr_sel == 2'd0) m_rise = wr_data;
        if (wr_sel == 2'd1) m_fall = wr_data;
        if (wr_sel == 2'd2) m_mask = wr_data;
      end
      h2 = h1; h1 = h0; h0 = line_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_out !== fold(m_pend & m_mask)) begin
        fails++;
        $display("FAIL R10 model compare: actual %b expected %b", irq_out, fold(m_pend & m_mask));
      end
    end
  end

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, irq_out, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_line(input int b, input logic v);
    @(negedge clk);
    line_in[b] = v;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    check("R1 reset", 7'b0000000);

    wr(2'd0, 16'h0405);
    wr(2'd1, 16'h0026);
    wr(2'd2, 16'hFFFF);

    set_line(0, 1'b1);
    wait_n(2);
    check("R10 not yet", 7'b0000000);
    wait_n(1);
    check("R2 rise line0", 7'b0000001);

    set_line(1, 1'b1);
    wait_n(4);
    check("R5 rise without enable", 7'b0000001);
    set_line(1, 1'b0);
    wait_n(3);
    check("R3 fall line1", 7'b0000011);

    set_line(2, 1'b1);
    wait_n(3);
    check("R4 rise line2", 7'b0000111);
    wr(2'd3, 16'h0004);
    check("R7 clear line2", 7'b0000011);
    set_line(2, 1'b0);
    wait_n(3);
    check("R4 fall line2", 7'b0000111);

    wr(2'd3, 16'h0000);
    check("R7 write zero ignored", 7'b0000111);

    wr(2'd2, 16'hFBFF);
    set_line(10, 1'b1);
    wait_n(3);
    check("R6 masked line10", 7'b0000111);
    wr(2'd2, 16'hFFFF);
    check("R6 unmask shows pending", 7'b1000111);

    set_line(5, 1'b1);
    wait_n(3);
    check("R5 line5 rise ignored", 7'b1000111);
    set_line(5, 1'b0);
    wait_n(3);
    check("R9 shared line5", 7'b1100111);
    wr(2'd3, 16'h0400);
    check("R9 shared group drops", 7'b0100111);

    wr(2'd3, 16'h0001);
    check("R7 clear line0", 7'b0100110);
    set_line(0, 1'b0);
    wait_n(3);
    check("R5 line0 fall ignored", 7'b0100110);
    set_line(0, 1'b1);
    wait_n(2);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h0001;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 edge beats clear", 7'b0100111);

    wr(2'd3, 16'hFFFF);
    check("R7 clear all", 7'b0000000);
    wait_n(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule